// File: doc/BRIEF.md
# Vector Indexed Access Legality Checker

This block sits in the decode stage of a vector-capable core. It reads a 32-bit instruction word and decides whether it is a vector indexed (gather/scatter) load or store. When it is, the block extracts the operand fields and decides whether the instruction is legal under the current vector configuration. The configuration is the log2 of the selected element width (SEW), the signed log2 of the register group multiplier (LMUL), and a flag that marks the configuration itself as unusable.

The index operand carries its own element width (EEW), taken from the width field, so its register group multiplier differs from the data group's. The block derives that index multiplier (EMUL). It then checks the EMUL range, the alignment of both register groups, the bounds of a multi-field segment, and the overlap between the destination groups and the index group. All checks are combinational. One register stage holds the result, so it appears one clock after the instruction is presented.

Top module: `vidx_legality_chk`

## Requirements
- R1: `acc_valid_o` is 1 only when all of the following hold:
  - opcode bits [6:0] are 0000111 (load) or 0100111 (store);
  - bit 26 is 1 and bit 28 is 0;
  - width bits [14:12] are 000, 101, 110 or 111, which give index EEW 8, 16, 32 or 64 and `idx_eew_o` = 0, 1, 2 or 3.

  Bit 27 gives `ordered_o`, and `is_store_o` is 1 for the store opcode. When `acc_valid_o` is 0, every other output is 0.
- R2: For a valid access, the outputs are taken from these instruction fields:
  - `nfields_o` = bits [31:29] + 1;
  - `unmasked_o` = bit 25;
  - `vs2_o` = bits [24:20];
  - `rs1_o` = bits [19:15];
  - `vd_o` = bits [11:7].
- R3: Results are registered. They appear after the rising edge that samples the inputs, and reset clears all outputs to 0.
- R4: A valid access is illegal when `cfg_bad_i` is 1, or when `cfg_lmul_i` holds the reserved code 3'b100.
- R5: EMUL = EEW_log2 − `cfg_sew_i` + LMUL_log2, where `cfg_sew_i` 0..3 means SEW 8..64 and `cfg_lmul_i` is 3-bit two's complement. The access is illegal unless −3 ≤ EMUL ≤ 3.
- R6: The index group size is 2^max(EMUL,0) and the data group size is 2^max(LMUL,0). `vs2` must be a multiple of the index group size and `vd` a multiple of the data group size; otherwise the access is illegal.
- R7: With NF fields and data group size G, the access is illegal if NF·G > 8 or if vd + NF·G − 1 > 31.
- R8: A masked load (bit 25 = 0) with vd = 0 is illegal.
- R9: On a load with EEW > SEW, a field's destination group (starting at vd + i·G) may overlap the vs2 group only if both groups start at the same register.
- R10: On a load with EEW < SEW, any overlap between a destination group and the vs2 group is illegal. With EEW = SEW and NF = 1, overlap is legal.
- R11: On a load with NF > 1, any overlap of any field's destination group with the vs2 group is illegal, even one with a shared start register.
- R12: Stores are checked only by R4–R7. The mask rule and the overlap rules have no effect on `illegal_o` for a store.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| insn_i | input | 32 | Instruction word |
| cfg_sew_i | input | 2 | log2(SEW/8) |
| cfg_lmul_i | input | 3 | Signed log2 LMUL, 3'b100 reserved |
| cfg_bad_i | input | 1 | Configuration unusable |
| acc_valid_o | output | 1 | Word is a vector indexed access |
| is_store_o | output | 1 | 1 = store, 0 = load |
| ordered_o | output | 1 | 1 = ordered indexed access |
| idx_eew_o | output | 2 | log2(index EEW/8) |
| nfields_o | output | 4 | Segment field count 1..8 |
| vd_o | output | 5 | Data register (destination or store source) |
| vs2_o | output | 5 | Index register |
| rs1_o | output | 5 | Base address register |
| unmasked_o | output | 1 | 1 = unmasked |
| illegal_o | output | 1 | Access is illegal |

## Verification
Every output, decoded fields and illegal flag alike, is due exactly one rising edge after the instruction and configuration are applied. Nothing in the block takes more than one cycle. The bench drives each vector on a falling edge and compares all outputs on the next falling edge, half a period after the capturing edge. This keeps every comparison in the single cycle where that vector's result is valid, and clear of the edge at which the next result is captured. The directed vectors place each rule's boundary in that cycle, for example a span of exactly 8, vd + span − 1 = 31, and a shared start register.

// File: rtl/vidx_pkg.sv
package vidx_pkg;
    localparam int REG_AW    = 5;
    localparam int NREGS     = 32;
    localparam int MAX_NF    = 8;
    localparam int NF_W      = 4;
    localparam int GRP_W     = 4;
    localparam int INSN_W    = 32;

    localparam logic [6:0] OPC_VLOAD  = 7'b0000111;
    localparam logic [6:0] OPC_VSTORE = 7'b0100111;

    typedef struct packed {
        logic              valid;
        logic              store;
        logic              ordered;
        logic [1:0]        eew;
        logic [NF_W-1:0]   nf;
        logic [REG_AW-1:0] vd;
        logic [REG_AW-1:0] vs2;
        logic [REG_AW-1:0] rs1;
        logic              vm;
        logic              illegal;
    } vidx_res_t;
endpackage

// File: rtl/vidx_decode.sv
module vidx_decode
    import vidx_pkg::*;
(
    input  logic [INSN_W-1:0] insn_i,
    output logic              hit_o,
    output logic              store_o,
    output logic              ordered_o,
    output logic [1:0]        eew_o,
    output logic [NF_W-1:0]   nf_o,
    output logic              vm_o,
    output logic [REG_AW-1:0] vd_o,
    output logic [REG_AW-1:0] vs2_o,
    output logic [REG_AW-1:0] rs1_o
);
    logic opc_ld, opc_st, width_ok;

    always_comb begin
        opc_ld   = (insn_i[6:0] == OPC_VLOAD);
        opc_st   = (insn_i[6:0] == OPC_VSTORE);
        width_ok = 1'b1;
        unique case (insn_i[14:12])
            3'b000:  eew_o = 2'd0;
            3'b101:  eew_o = 2'd1;
            3'b110:  eew_o = 2'd2;
            3'b111:  eew_o = 2'd3;
            default: begin
                eew_o    = 2'd0;
                width_ok = 1'b0;
            end
        endcase
        hit_o     = (opc_ld | opc_st) & width_ok & insn_i[26] & ~insn_i[28];
        store_o   = opc_st;
        ordered_o = insn_i[27];
        nf_o      = {1'b0, insn_i[31:29]} + 4'd1;
        vm_o      = insn_i[25];
        vs2_o     = insn_i[24:20];
        rs1_o     = insn_i[19:15];
        vd_o      = insn_i[11:7];
    end
endmodule

// File: rtl/vidx_geom.sv
module vidx_geom
    import vidx_pkg::*;
#(
    parameter int SPAN_LIMIT = 8,
    parameter int REG_COUNT  = NREGS
) (
    input  logic [1:0]        eew_i,
    input  logic [1:0]        sew_i,
    input  logic [2:0]        lmul_i,
    input  logic [NF_W-1:0]   nf_i,
    input  logic [REG_AW-1:0] vd_i,
    input  logic [REG_AW-1:0] vs2_i,
    output logic              emul_ok_o,
    output logic              align_ok_o,
    output logic              seg_ok_o,
    output logic [GRP_W-1:0]  dgrp_o,
    output logic [GRP_W-1:0]  igrp_o
);
    localparam int SW = 8;

    logic signed [4:0] emul;
    logic [1:0]        lmul_pos, emul_pos;
    logic [SW-1:0]     span;
    logic [REG_AW-1:0] imask, dmask;

    always_comb begin
        emul = $signed({3'b000, eew_i}) - $signed({3'b000, sew_i})
             + $signed({{2{lmul_i[2]}}, lmul_i});
        emul_ok_o = (emul >= -5'sd3) && (emul <= 5'sd3);

        lmul_pos = lmul_i[2] ? 2'd0 : lmul_i[1:0];
        if (emul[4])           emul_pos = 2'd0;
        else if (emul > 5'sd3) emul_pos = 2'd3;
        else                   emul_pos = emul[1:0];

        dgrp_o = GRP_W'(1) << lmul_pos;
        igrp_o = GRP_W'(1) << emul_pos;

        imask = {1'b0, igrp_o} - 5'd1;
        dmask = {1'b0, dgrp_o} - 5'd1;
        align_ok_o = ((vs2_i & imask) == '0) && ((vd_i & dmask) == '0);

        span     = SW'(nf_i) * SW'(dgrp_o);
        seg_ok_o = (span <= SW'(SPAN_LIMIT))
                && ((SW'(vd_i) + span) <= SW'(REG_COUNT));
    end
endmodule

// File: rtl/vidx_overlap.sv
module vidx_overlap
    import vidx_pkg::*;
#(
    parameter int FIELDS = MAX_NF
) (
    input  logic [NF_W-1:0]   nf_i,
    input  logic [REG_AW-1:0] vd_i,
    input  logic [REG_AW-1:0] vs2_i,
    input  logic [GRP_W-1:0]  dgrp_i,
    input  logic [GRP_W-1:0]  igrp_i,
    input  logic              eew_gt_i,
    input  logic              eew_lt_i,
    output logic              conflict_o
);
    localparam int AW = 8;

    logic [FIELDS-1:0] bad;
    logic              multi;
    logic [AW-1:0]     idx_lo, idx_hi;

    assign multi  = (nf_i > 4'd1);
    assign idx_lo = AW'(vs2_i);
    assign idx_hi = AW'(vs2_i) + AW'(igrp_i);

    for (genvar f = 0; f < FIELDS; f++) begin : g_field
        logic [AW-1:0] seg_lo, seg_hi;
        logic          active, ovl, same;
        always_comb begin
            seg_lo = AW'(vd_i) + AW'(f) * AW'(dgrp_i);
            seg_hi = seg_lo + AW'(dgrp_i);
            active = (NF_W'(f) < nf_i);
            ovl    = (seg_lo < idx_hi) && (idx_lo < seg_hi);
            same   = (seg_lo == idx_lo);
            bad[f] = active && ovl && (multi || eew_lt_i || (eew_gt_i && !same));
        end
    end

    assign conflict_o = |bad;
endmodule

// File: rtl/vidx_legality_chk.sv
module vidx_legality_chk
    import vidx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       insn_i,
    input  logic [1:0]        cfg_sew_i,
    input  logic [2:0]        cfg_lmul_i,
    input  logic              cfg_bad_i,
    output logic              acc_valid_o,
    output logic              is_store_o,
    output logic              ordered_o,
    output logic [1:0]        idx_eew_o,
    output logic [3:0]        nfields_o,
    output logic [4:0]        vd_o,
    output logic [4:0]        vs2_o,
    output logic [4:0]        rs1_o,
    output logic              unmasked_o,
    output logic              illegal_o
);
    logic              hit, st, ord, vm;
    logic [1:0]        eew;
    logic [NF_W-1:0]   nf;
    logic [REG_AW-1:0] vd, vs2, rs1;
    logic              emul_ok, align_ok, seg_ok, conflict;
    logic [GRP_W-1:0]  dgrp, igrp;
    logic              cfg_fail, load_fail;

    vidx_res_t res_d, res_q;

    vidx_decode i_dec (
        .insn_i(insn_i), .hit_o(hit), .store_o(st), .ordered_o(ord),
        .eew_o(eew), .nf_o(nf), .vm_o(vm), .vd_o(vd), .vs2_o(vs2), .rs1_o(rs1)
    );

    vidx_geom i_geom (
        .eew_i(eew), .sew_i(cfg_sew_i), .lmul_i(cfg_lmul_i), .nf_i(nf),
        .vd_i(vd), .vs2_i(vs2), .emul_ok_o(emul_ok), .align_ok_o(align_ok),
        .seg_ok_o(seg_ok), .dgrp_o(dgrp), .igrp_o(igrp)
    );

    vidx_overlap i_ovl (
        .nf_i(nf), .vd_i(vd), .vs2_i(vs2), .dgrp_i(dgrp), .igrp_i(igrp),
        .eew_gt_i(eew > cfg_sew_i), .eew_lt_i(eew < cfg_sew_i),
        .conflict_o(conflict)
    );

    always_comb begin
        cfg_fail  = cfg_bad_i || (cfg_lmul_i == 3'b100);
        load_fail = !st && ((!vm && (vd == '0)) || conflict);
        res_d = '0;
        if (hit) begin
            res_d.valid   = 1'b1;
            res_d.store   = st;
            res_d.ordered = ord;
            res_d.eew     = eew;
            res_d.nf      = nf;
            res_d.vd      = vd;
            res_d.vs2     = vs2;
            res_d.rs1     = rs1;
            res_d.vm      = vm;
            res_d.illegal = cfg_fail || !emul_ok || !align_ok || !seg_ok || load_fail;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign acc_valid_o = res_q.valid;
    assign is_store_o  = res_q.store;
    assign ordered_o   = res_q.ordered;
    assign idx_eew_o   = res_q.eew;
    assign nfields_o   = res_q.nf;
    assign vd_o        = res_q.vd;
    assign vs2_o       = res_q.vs2;
    assign rs1_o       = res_q.rs1;
    assign unmasked_o  = res_q.vm;
    assign illegal_o   = res_q.illegal;

    // R1: a word that is not an indexed access never reports illegal
    p_quiet_when_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid_o |-> !illegal_o && nfields_o == '0);

    // R2: field count is never zero for a decoded access
    p_nf_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid_o |-> nfields_o != '0);

    // R4: unusable configuration forces illegal
    p_badcfg_r4: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid_o && $past(cfg_bad_i) |-> illegal_o);

    // R5: legal results always had EMUL within -3..3
    p_emul_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid_o && !illegal_o |->
            ($signed({3'b000, idx_eew_o}) - $signed({3'b000, $past(cfg_sew_i)})
             + $signed({{2{$past(cfg_lmul_i[2])}}, $past(cfg_lmul_i)})) >= -5'sd3);

    // R7: legal segment never passes the last register
    p_seg_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid_o && !illegal_o |-> (6'(vd_o) + 6'(nfields_o)) <= 6'd32);

    // R8: a legal masked load never writes v0
    p_mask_v0_r8: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid_o && !is_store_o && !unmasked_o && !illegal_o |-> vd_o != '0);
endmodule

// File: tb/test_vidx_legality_chk.sv
`timescale 1ns/1ps
module test_vidx_legality_chk;
    typedef struct packed {
        logic       valid, store, ordered;
        logic [1:0] eew;
        logic [3:0] nf;
        logic [4:0] vd, vs2, rs1;
        logic       vm, illegal;
    } obs_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] insn = '0;
    logic [1:0]  sew = '0;
    logic [2:0]  lmul = '0;
    logic        bad = 1'b0;
    obs_t        got;
    int          n_chk = 0, n_bad = 0;
    bit          done = 0;

    always #2 clk = ~clk;

    vidx_legality_chk i_vidx_legality_chk (
        .clk(clk), .rst_n(rst_n), .insn_i(insn), .cfg_sew_i(sew),
        .cfg_lmul_i(lmul), .cfg_bad_i(bad),
        .acc_valid_o(got.valid), .is_store_o(got.store), .ordered_o(got.ordered),
        .idx_eew_o(got.eew), .nfields_o(got.nf), .vd_o(got.vd), .vs2_o(got.vs2),
        .rs1_o(got.rs1), .unmasked_o(got.vm), .illegal_o(got.illegal)
    );

    localparam logic [2:0] W8 = 3'b000, W16 = 3'b101, W32 = 3'b110, W64 = 3'b111;

    function automatic logic [31:0] mk(bit ld, bit ord, logic [2:0] w, logic [2:0] nfm1,
                                       bit vm, logic [4:0] vs2, logic [4:0] rs1,
                                       logic [4:0] vd);
        return {nfm1, 1'b0, ord, 1'b1, vm, vs2, rs1, w, vd,
                ld ? 7'b0000111 : 7'b0100111};
    endfunction

    function automatic obs_t model(logic [31:0] w, logic [1:0] s, logic [2:0] l, bit b);
        obs_t r = '0;
        int e, lm, em, d, g, nf, vd, vs2, sw;
        bit ld, st, ill;
        ld = (w[6:0] == 7'b0000111);
        st = (w[6:0] == 7'b0100111);
        case (w[14:12])
            3'b000: e = 0; 3'b101: e = 1; 3'b110: e = 2; 3'b111: e = 3;
            default: e = -1;
        endcase
        if (!(ld || st) || e < 0 || !w[26] || w[28]) return r;
        sw  = int'(s);
        nf  = int'(w[31:29]) + 1;
        vd  = int'(w[11:7]);
        vs2 = int'(w[24:20]);
        lm  = l[2] ? int'(l) - 8 : int'(l);
        em  = e - sw + lm;
        ill = b || lm == -4 || em < -3 || em > 3;
        d = 1 << (lm > 0 ? lm : 0);
        g = 1 << (em > 0 ? em : 0);
        if (vs2 % g != 0 || vd % d != 0) ill = 1;
        if (nf * d > 8 || vd + nf * d - 1 > 31) ill = 1;
        if (ld) begin
            if (!w[25] && vd == 0) ill = 1;
            for (int f = 0; f < nf; f++) begin
                int s0 = vd + f * d;
                if (s0 < vs2 + g && vs2 < s0 + d) begin
                    if (nf > 1) ill = 1;
                    else if (e < sw) ill = 1;
                    else if (e > sw && s0 != vs2) ill = 1;
                end
            end
        end
        r.valid = 1; r.store = st; r.ordered = w[27]; r.eew = 2'(e);
        r.nf = 4'(nf); r.vd = w[11:7]; r.vs2 = w[24:20]; r.rs1 = w[19:15];
        r.vm = w[25]; r.illegal = ill;
        return r;
    endfunction

    task automatic report(string tag, obs_t a, obs_t x);
        n_chk++;
        if (a !== x) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h (insn %h sew %0d lmul %0d bad %0d)",
                     tag, a, x, insn, sew, lmul, bad);
        end
    endtask

    // drive on falling edge, result captured at next rising edge, compare at next falling edge
    task automatic apply(string tag, logic [31:0] w, logic [1:0] s, logic [2:0] l, bit b,
                         int exp_valid, int exp_ill);
        obs_t x;
        insn = w; sew = s; lmul = l; bad = b;
        x = model(w, s, l, b);
        if (exp_valid >= 0) x.valid = exp_valid[0];
        if (exp_ill >= 0)   x.illegal = exp_ill[0];
        @(negedge clk);
        report(tag, got, x);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(4 * 200000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        insn = mk(1, 1, W32, 3'd2, 1, 5'd24, 5'd13, 5'd3);
        sew = 2'd2;
        repeat (3) @(negedge clk);
        report("R3 reset clears outputs", got, '0);
        rst_n = 1'b1;

        // R1 decode
        apply("R1 bad opcode", {mk(1,0,W8,0,1,8,1,4)} & ~32'h7F | 32'h23, 0, 0, 0, 0, 0);
        apply("R1 bad width", (mk(1,0,W8,0,1,8,1,4) & ~32'h7000) | 32'h1000, 0, 0, 0, 0, 0);
        apply("R1 bit26 clear", mk(1,0,W8,0,1,8,1,4) & ~32'h0400_0000, 0, 0, 0, 0, 0);
        apply("R1 bit28 set", mk(1,0,W8,0,1,8,1,4) | 32'h1000_0000, 0, 0, 0, 0, 0);
        apply("R1 store unordered", mk(0,0,W64,0,1,0,2,8), 3, 0, 0, 1, 0);
        // R2 fields
        apply("R2 field extraction", mk(1,1,W32,3'd2,1,5'd24,5'd13,5'd3), 2, 0, 0, 1, 0);
        // R4 config
        apply("R4 cfg bad", mk(1,1,W32,0,1,24,13,3), 2, 0, 1, 1, 1);
        apply("R4 reserved lmul", mk(1,1,W32,0,1,24,13,3), 2, 3'b100, 0, 1, 1);
        // R5 EMUL range
        apply("R5 emul +4", mk(0,0,W64,0,1,0,1,0), 0, 3'd1, 0, 1, 1);
        apply("R5 emul -4", mk(0,0,W8,0,1,0,1,0), 3, 3'b111, 0, 1, 1);
        apply("R5 emul -3", mk(0,0,W8,0,1,16,1,8), 0, 3'b101, 0, 1, 0);
        // R6 alignment
        apply("R6 vs2 misaligned", mk(0,0,W16,0,1,6,1,2), 0, 3'd1, 0, 1, 1);
        apply("R6 vd misaligned", mk(0,0,W16,0,1,8,1,3), 0, 3'd1, 0, 1, 1);
        apply("R6 aligned", mk(0,0,W16,0,1,8,1,2), 0, 3'd1, 0, 1, 0);
        // R7 segment bounds
        apply("R7 span 8", mk(0,0,W8,3'd3,1,0,1,2), 0, 3'd1, 0, 1, 0);
        apply("R7 span 10", mk(0,0,W8,3'd4,1,0,1,2), 0, 3'd1, 0, 1, 1);
        apply("R7 past v31", mk(0,0,W8,3'd4,1,0,1,28), 0, 3'd0, 0, 1, 1);
        apply("R7 ends v31", mk(0,0,W8,3'd3,1,0,1,28), 0, 3'd0, 0, 1, 0);
        // R8 mask
        apply("R8 masked load v0", mk(1,0,W8,0,0,8,1,0), 0, 0, 0, 1, 1);
        apply("R8 masked load v1", mk(1,0,W8,0,0,8,1,1), 0, 0, 0, 1, 0);
        apply("R12 masked store v0", mk(0,0,W8,0,0,8,1,0), 0, 0, 0, 1, 0);
        // R9 EEW > SEW
        apply("R9 same start", mk(1,0,W16,0,1,4,1,4), 0, 0, 0, 1, 0);
        apply("R9 offset overlap", mk(1,0,W16,0,1,4,1,5), 0, 0, 0, 1, 1);
        apply("R9 disjoint", mk(1,0,W16,0,1,4,1,6), 0, 0, 0, 1, 0);
        // R10 EEW < SEW and equal
        apply("R10 narrow overlap", mk(1,0,W8,0,1,5,1,4), 1, 3'd1, 0, 1, 1);
        apply("R10 narrow disjoint", mk(1,0,W8,0,1,6,1,4), 1, 3'd1, 0, 1, 0);
        apply("R10 equal overlap", mk(1,0,W16,0,1,7,1,7), 1, 0, 0, 1, 0);
        apply("R12 store narrow overlap", mk(0,0,W8,0,1,5,1,4), 1, 3'd1, 0, 1, 0);
        // R11 segments
        apply("R11 seg overlap f1", mk(1,0,W8,3'd1,1,5,1,4), 0, 0, 0, 1, 1);
        apply("R11 seg same start", mk(1,0,W8,3'd1,1,4,1,4), 0, 0, 0, 1, 1);
        apply("R11 seg disjoint", mk(1,0,W8,3'd1,1,6,1,4), 0, 0, 0, 1, 0);
        apply("R12 store seg overlap", mk(0,0,W8,3'd1,1,5,1,4), 0, 0, 0, 1, 0);

        // random mix: decode R1 R2, legality R4 R5 R6 R7 R8 R9 R10 R11 R12
        for (int k = 0; k < 4000; k++) begin
            logic [31:0] w;
            logic [2:0]  wc;
            w = $urandom;
            if ($urandom % 8 != 0) w[6:0] = ($urandom % 2) ? 7'b0000111 : 7'b0100111;
            if ($urandom % 4 != 0) begin w[28] = 1'b0; w[26] = 1'b1; end
            if ($urandom % 8 != 0) begin
                case ($urandom % 4)
                    0: wc = W8; 1: wc = W16; 2: wc = W32; default: wc = W64;
                endcase
                w[14:12] = wc;
            end
            if ($urandom % 2) w[31:29] = 3'd0;
            if ($urandom % 2) begin w[24:20] = 5'($urandom % 12); w[11:7] = 5'($urandom % 12); end
            apply("R1 R2 R4 R5 R6 R7 R8 R9 R10 R11 R12 random", w, 2'($urandom),
                  3'($urandom), ($urandom % 16) == 0, -1, -1);
        end
        finish_run();
    end
endmodule